// File: doc/BRIEF.md
# Card Controller Status and Interrupt Register File

This block holds the status, clear, mask and small configuration registers of a memory-card host controller. It sits on a simple single-cycle read/write bus. Eleven sticky event bits come in from the command and data engines as one-cycle pulses and stay set until software clears them. Eleven live FIFO condition bits pass straight through into the upper part of the same status word. They are never latched and software cannot clear them.

A write-one-to-clear register lets software clear sticky events. Any number of mask registers (two by default) each drive their own registered interrupt line from the shared status. A read-only window at the top of the address space returns eight identification bytes, one per word. Three 8-bit configuration registers (power, clock and data control) are stored here and driven out to the rest of the controller.

The bus side is a two-state machine. `ST_IDLE` is the rest state. `ST_RESP` is the cycle in which read data is valid. Transitions: ST_IDLE to ST_RESP on a read request. ST_RESP to ST_RESP on a back-to-back read request. ST_RESP to ST_IDLE when no read is requested. ST_IDLE stays in ST_IDLE on a write or no request. Writes are taken in either state.

Top module: `sdstat_top`

## Requirements
- R1: After reset, all sticky bits, masks, configuration registers, interrupt outputs and `bus_rvalid` are zero, and the bus machine is in ST_IDLE.
- R2: A one on `evt_set[i]` for i in {0..8, 10} sets status bit i on the next clock edge. The bit stays set until cleared. Status bit 9 always reads 0, whatever `evt_set[9]` does.
- R3: A write to offset 0x38 clears each status bit in [10:0] where the write data holds a one. Write data bits above 10 have no effect, and the live bits are unaffected.
- R4: When an event pulse and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R5: Status bits [21:11] equal `live_flags[10:0]` in the cycle they are read, and are not held once the input drops. Status bits [31:22] read 0.
- R6: Interrupt line k is a register that takes the OR of (status AND mask k). It changes one clock after the status or mask change.
- R7: Mask k is written and read at offset 0x3C + 4k. Only bits [21:0] are kept.
- R8: Reads at 0xFE0 + 4n, for n = 0..7, return in bits [7:0] the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in order of n. Upper bits read 0, and writes there have no effect.
- R9: Power (0x00), clock (0x04) and data control (0x2C) keep only write data bits [7:0]. They read back zero-extended and drive `power_o`, `clock_o` and `dctrl_o`.
- R10: A read request sets `bus_rvalid` and `bus_rdata` in the following cycle only. Unmapped offsets read 0. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, the cycle after a read request |
| evt_set | input | 11 | Event pulses, bit i sets status bit i |
| live_flags | input | 11 | Live FIFO conditions, shown at status [21:11] |
| irq_o | output | 2 | Masked interrupt lines, one per mask |
| power_o | output | 8 | Power register |
| clock_o | output | 8 | Clock register |
| dctrl_o | output | 8 | Data control register |

## Verification
An event pulse or clear write is taken at one clock edge and shows in status from the next cycle. Interrupt lines lag by one further edge. A read request returns its data in the cycle after the request. The bench drives every stimulus on the falling edge and samples results on the following falling edge. For the interrupt lines it checks both falling edges: the first must still show the old value and the second the new one. This catches an interrupt path that is one cycle too fast or too slow.

// File: rtl/sdstat_pkg.sv
package sdstat_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int EVT_W  = 11;
    localparam int LIVE_W = 11;
    localparam int STAT_W = EVT_W + LIVE_W;
    localparam int IDX_W  = 3;
    localparam int ID_N   = 8;

    // bit 9 carries no event
    localparam logic [EVT_W-1:0] EVT_IMPL = 11'h5FF;

    localparam logic [ADDR_W-1:0] OFS_POWER  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CLOCK  = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_DCTRL  = 12'h02C;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h038;
    localparam logic [ADDR_W-1:0] OFS_MASK0  = 12'h03C;
    localparam logic [ADDR_W-1:0] OFS_ID0    = 12'hFE0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_POWER,
        SEL_CLOCK,
        SEL_DCTRL,
        SEL_STATUS,
        SEL_CLEAR,
        SEL_MASK,
        SEL_ID
    } sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_st_e;

    function automatic logic [7:0] id_byte(input logic [IDX_W-1:0] n);
        logic [7:0] b;
        unique case (n)
            3'd0: b = 8'h81;
            3'd1: b = 8'h11;
            3'd2: b = 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sdstat_decode.sv
module sdstat_decode
    import sdstat_pkg::*;
#(
    parameter int N_IRQ = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_e              sel,
    output logic [IDX_W-1:0]  idx
);
    localparam int WA_W = ADDR_W - 2;

    logic [WA_W-1:0] wa;
    logic [1:0]      unused_lsb;

    assign wa         = addr[ADDR_W-1:2];
    assign unused_lsb = addr[1:0];

    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        if (wa == OFS_POWER[ADDR_W-1:2])  sel = SEL_POWER;
        if (wa == OFS_CLOCK[ADDR_W-1:2])  sel = SEL_CLOCK;
        if (wa == OFS_DCTRL[ADDR_W-1:2])  sel = SEL_DCTRL;
        if (wa == OFS_STATUS[ADDR_W-1:2]) sel = SEL_STATUS;
        if (wa == OFS_CLEAR[ADDR_W-1:2])  sel = SEL_CLEAR;
        for (int k = 0; k < N_IRQ; k++) begin
            if (wa == WA_W'(OFS_MASK0[ADDR_W-1:2] + WA_W'(k))) begin
                sel = SEL_MASK;
                idx = IDX_W'(k);
            end
        end
        for (int n = 0; n < ID_N; n++) begin
            if (wa == WA_W'(OFS_ID0[ADDR_W-1:2] + WA_W'(n))) begin
                sel = SEL_ID;
                idx = IDX_W'(n);
            end
        end
    end

    always_comb begin
        assert (sel != SEL_MASK || int'(idx) < N_IRQ) else $error("AST_MASK_IDX_RANGE"); // R7
    end

endmodule

// File: rtl/sdstat_events.sv
module sdstat_events
    import sdstat_pkg::*;
#(
    parameter int                W    = EVT_W,
    parameter logic [EVT_W-1:0]  IMPL = EVT_IMPL
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_set,
    input  logic         clr_en,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] sticky
);
    logic unused_bits;
    assign unused_bits = ^(evt_set & ~IMPL[W-1:0]) ^ ^(clr_bits & ~IMPL[W-1:0]);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_flop
            always_ff @(posedge clk) begin
                if (!rst_n)
                    sticky[i] <= 1'b0;
                else if (evt_set[i])
                    sticky[i] <= 1'b1;
                else if (clr_en && clr_bits[i])
                    sticky[i] <= 1'b0;
            end
        end else begin : g_tie
            assign sticky[i] = 1'b0;
        end
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((evt_set & IMPL[W-1:0]) != '0) |=> ((sticky & $past(evt_set & IMPL[W-1:0])) == $past(evt_set & IMPL[W-1:0]))); // R4
    AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(sticky) & ~sticky & ~($past(clr_bits) & {W{$past(clr_en)}})) == '0)); // R3
    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((sticky & ~IMPL[W-1:0]) == '0)); // R2

endmodule

// File: rtl/sdstat_irq.sv
module sdstat_irq
    import sdstat_pkg::*;
#(
    parameter int N_IRQ = 2,
    parameter int W     = STAT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     status,
    input  logic [W-1:0]     mask [N_IRQ],
    output logic [N_IRQ-1:0] irq
);
    for (genvar k = 0; k < N_IRQ; k++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n)
                irq[k] <= 1'b0;
            else
                irq[k] <= |(status & mask[k]);
        end

        AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            ((status & mask[k]) == '0) |=> !irq[k]); // R6
        AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
            ((status & mask[k]) != '0) |=> irq[k]); // R6
    end

endmodule

// File: rtl/sdstat_top.sv
module sdstat_top
    import sdstat_pkg::*;
#(
    parameter int N_IRQ = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic [EVT_W-1:0]  evt_set,
    input  logic [LIVE_W-1:0] live_flags,
    output logic [N_IRQ-1:0]  irq_o,
    output logic [7:0]        power_o,
    output logic [7:0]        clock_o,
    output logic [7:0]        dctrl_o
);
    sel_e             sel;
    logic [IDX_W-1:0] idx;
    bus_st_e          state_q, state_d;
    logic             rd_req, wr_req;
    logic [EVT_W-1:0] sticky;
    logic [STAT_W-1:0] status;
    logic [STAT_W-1:0] mask_q [N_IRQ];
    logic [7:0]       power_q, clock_q, dctrl_q;
    logic [DATA_W-1:0] rd_mux, rdata_q;
    logic             unused_wdata;

    assign rd_req       = bus_req && !bus_we;
    assign wr_req       = bus_req && bus_we;
    assign unused_wdata = ^bus_wdata[DATA_W-1:STAT_W];

    sdstat_decode #(.N_IRQ(N_IRQ)) u_decode (
        .addr (bus_addr),
        .sel  (sel),
        .idx  (idx)
    );

    sdstat_events #(.W(EVT_W), .IMPL(EVT_IMPL)) u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_set  (evt_set),
        .clr_en   (wr_req && sel == SEL_CLEAR),
        .clr_bits (bus_wdata[EVT_W-1:0]),
        .sticky   (sticky)
    );

    assign status = {live_flags, sticky};

    sdstat_irq #(.N_IRQ(N_IRQ), .W(STAT_W)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .status (status),
        .mask   (mask_q),
        .irq    (irq_o)
    );

    // configuration and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            power_q <= '0;
            clock_q <= '0;
            dctrl_q <= '0;
        end else if (wr_req) begin
            if (sel == SEL_POWER) power_q <= bus_wdata[7:0];
            if (sel == SEL_CLOCK) clock_q <= bus_wdata[7:0];
            if (sel == SEL_DCTRL) dctrl_q <= bus_wdata[7:0];
        end
    end

    for (genvar k = 0; k < N_IRQ; k++) begin : g_mask
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q[k] <= '0;
            else if (wr_req && sel == SEL_MASK && int'(idx) == k)
                mask_q[k] <= bus_wdata[STAT_W-1:0];
        end
    end

    assign power_o = power_q;
    assign clock_o = clock_q;
    assign dctrl_o = dctrl_q;

    // read data selection
    always_comb begin
        rd_mux = '0;
        unique case (sel)
            SEL_POWER:  rd_mux = DATA_W'(power_q);
            SEL_CLOCK:  rd_mux = DATA_W'(clock_q);
            SEL_DCTRL:  rd_mux = DATA_W'(dctrl_q);
            SEL_STATUS: rd_mux = DATA_W'(status);
            SEL_MASK:   rd_mux = DATA_W'(mask_q[idx[$clog2(N_IRQ > 1 ? N_IRQ : 2)-1:0]]);
            SEL_ID:     rd_mux = DATA_W'(id_byte(idx));
            default:    rd_mux = '0;
        endcase
    end

    // bus state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_req) rdata_q <= rd_mux;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // bus outputs
    always_comb begin
        bus_rvalid = (state_q == ST_RESP);
        bus_rdata  = bus_rvalid ? rdata_q : '0;
    end

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid); // R10
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(rd_req)); // R10
    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> $stable(power_o) && $stable(clock_o) && $stable(dctrl_o)); // R9

endmodule

// File: tb/test_sdstat_top.sv
module test_sdstat_top;
    import sdstat_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [10:0] evt_set = '0;
    logic [10:0] live_flags = '0;
    logic [1:0]  irq_o;
    logic [7:0]  power_o, clock_o, dctrl_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdstat_top i_sdstat_top (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .evt_set(evt_set), .live_flags(live_flags),
        .irq_o(irq_o), .power_o(power_o), .clock_o(clock_o), .dctrl_o(dctrl_o)
    );

    // evt, live, clear data, expected status
    typedef struct packed {
        logic [10:0] evt;
        logic [10:0] live;
        logic [31:0] clr;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{11'h001, 11'h000, 32'h0000_0000, 32'h0000_0001},
        '{11'h7FF, 11'h000, 32'h0000_0000, 32'h0000_05FF},
        '{11'h7FF, 11'h7FF, 32'h0000_00F0, 32'h003F_FD0F},
        '{11'h140, 11'h155, 32'h0000_0100, 32'h000A_A840},
        '{11'h00C, 11'h002, 32'hFFFF_FFFF, 32'h0000_1000},
        '{11'h400, 11'h400, 32'h0000_03FF, 32'h0020_0400}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_req = 1'b0;
        d = bus_rvalid ? bus_rdata : 32'hDEAD_BEEF;
    endtask

    task automatic pulse(input logic [10:0] e);
        @(negedge clk);
        evt_set = e;
        @(negedge clk);
        evt_set = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rvalid", {31'b0, bus_rvalid}, 32'h0);
        check("R1 irq", {30'b0, irq_o}, 32'h0);
        check("R1 cfg", {8'b0, power_o, clock_o, dctrl_o}, 32'h0);
        rst_n = 1'b1;
        rd(12'h034, d); check("R1 status", d, 32'h0);
        rd(12'h03C, d); check("R1 mask0", d, 32'h0);

        // R2 R3 R5 table
        for (int i = 0; i < 6; i++) begin
            wr(12'h038, 32'h0000_07FF);
            live_flags = VECS[i].live;
            pulse(VECS[i].evt);
            wr(12'h038, VECS[i].clr);
            rd(12'h034, d);
            check($sformatf("R2/R3/R5 row%0d", i), d, VECS[i].exp);
        end
        // R5 live not held
        live_flags = '0;
        rd(12'h034, d); check("R5 live dropped", d & 32'hFFFF_F800, 32'h0);

        // R4 set wins over same-cycle clear
        wr(12'h038, 32'h7FF);
        @(negedge clk);
        evt_set = 11'h004; bus_req = 1'b1; bus_we = 1'b1; bus_addr = 12'h038; bus_wdata = 32'h004;
        @(negedge clk);
        evt_set = '0; bus_req = 1'b0; bus_we = 1'b0;
        rd(12'h034, d); check("R4 set wins", d, 32'h4);
        wr(12'h038, 32'h7FF);

        // R7 mask readback, width
        wr(12'h03C, 32'hFFFF_FFFF);
        rd(12'h03C, d); check("R7 mask0 width", d, 32'h003F_FFFF);
        wr(12'h03C, 32'h0000_0040);
        wr(12'h040, 32'h0000_1000);
        rd(12'h040, d); check("R7 mask1", d, 32'h0000_1000);

        // R6 irq timing
        @(negedge clk);
        evt_set = 11'h040;
        @(negedge clk);
        evt_set = '0;
        check("R6 irq0 not yet", {31'b0, irq_o[0]}, 32'h0);
        @(negedge clk);
        check("R6 irq0 raised", {30'b0, irq_o}, 32'h1);
        @(negedge clk);
        live_flags = 11'h002;
        @(negedge clk);
        check("R6 irq1 raised", {30'b0, irq_o}, 32'h3);
        live_flags = '0;
        wr(12'h038, 32'h040);
        check("R6 irq0 not yet cleared", {30'b0, irq_o}, 32'h1);
        @(negedge clk);
        check("R6 irqs low", {30'b0, irq_o}, 32'h0);

        // R8 identification
        for (int n = 0; n < 8; n++) begin
            logic [7:0] e;
            case (n)
                0: e = 8'h81; 1: e = 8'h11; 2: e = 8'h04; 3: e = 8'h00;
                4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
            endcase
            rd(12'hFE0 + 12'(4 * n), d);
            check($sformatf("R8 id%0d", n), d, {24'b0, e});
        end
        wr(12'hFE0, 32'h0);
        rd(12'hFE0, d); check("R8 id write ignored", d, 32'h81);

        // R9 configuration
        wr(12'h000, 32'h0000_01A5);
        wr(12'h004, 32'hFFFF_FF3C);
        wr(12'h02C, 32'h0000_0107);
        rd(12'h000, d); check("R9 power", d, 32'hA5);
        rd(12'h004, d); check("R9 clock", d, 32'h3C);
        rd(12'h02C, d); check("R9 dctrl", d, 32'h07);
        check("R9 outputs", {8'b0, power_o, clock_o, dctrl_o}, 32'h00A5_3C07);

        // R10 unmapped, low address bits, rvalid one cycle
        rd(12'h044, d); check("R10 unmapped", d, 32'h0);
        rd(12'h003, d); check("R10 addr lsb", d, 32'hA5);
        @(negedge clk);
        check("R10 rvalid drops", {31'b0, bus_rvalid}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule